// File: doc/BRIEF.md
# Programmable Trigger State Sequencer

This block is the decision core of a logic-capture trigger. It walks through up to sixteen programmed states. In every state it tests an ordered list of sixteen if/then clauses against the current sample's recognizer events and the conditions of two built-in 51-bit counter/timers. Each clause is the AND of eight event slots. When one or more clauses match, the lowest-numbered one applies its eight actions together in one clock. Those actions can jump to another state, fire the capture trigger, steer sample storage, take a snapshot, drive a small set of output flags, and step, start, stop or clear the counter/timers.

Samples arrive as a stream: `evt_valid_i` qualifies `evt_i`. The sequencer always accepts a sample, so there is no ready signal and no back-pressure. Cycles without a valid sample evaluate nothing, but running timers keep counting. Clause tables and counter limits load through a plain write port. `arm_i` starts a capture run.

Top module: `trig_seq`

## Requirements
- R1: A write with `cfg_we_i` high stores `cfg_wdata_i` at the clock edge. The target is chosen by `cfg_addr_i` = {kind[9:8], state[7:4], clause[3:0]}. Kind 0 writes a clause's event word and kind 1 writes its action word. Kind 2 writes the 51-bit compare limit of counter unit clause[0]. After reset every clause is disabled and both limits are 0.
- R2: An event word holds eight 5-bit slot selects at bits [5j+4:5j] and an enable at bit 40. A clause matches only when it is enabled and all eight of its slots are true. The slot codes are:
  - 0 to 15: the matching bit of `evt_i`.
  - 16: counter unit 0 equals its limit.
  - 17: counter unit 1 equals its limit.
  - 31: always true.
  - 18 to 30: never true.
- R3: When several clauses of the current state match, only the lowest-numbered one has its actions applied.
- R4: A goto action sets `state_o` to its argument at the next clock, and the highest-numbered goto slot wins. If no clause matches, the state holds and no action is issued.
- R5: No clause is evaluated before the first arm, or in a cycle where `evt_valid_i` is low. In such a cycle `trig_o`, `store_o` and `snap_o` go low one clock later, and the state and flags do not change.
- R6: A trigger action raises `trig_o` for exactly one clock, one clock after the matching sample. Later trigger actions are ignored until the next arm.
- R7: `store_o` is registered. For a valid sample it equals store-now OR (next gate AND NOT skip-store). The gate is the store window: stop-store clears it, start-store sets it, and stop wins when both are given. In a cycle with no match, the gate holds its value.
- R8: Each counter unit (selected by argument bit 0) works as follows:
  - Reset beats everything else.
  - Otherwise the new value is old + running + increment − decrement, modulo 2^51.
  - Timer start and stop change the running flag from the next clock, and stop wins over start.
  - Both reset actions clear the value.
- R9: A counter change made by the actions of one sample is visible to slot codes 16 and 17 on the next cycle.
- R10: A snapshot action pulses `snap_o` for one clock. Flag set and flag clear act on `sig_o` bit (argument), and clear wins over set.
- R11: An arm moves the block to state 0, clears and stops both counter/timers, clears the flags, the store gate and the one-shot trigger lock, and suppresses evaluation in that cycle.
- R12: Each action byte j of the action word sits at bits [8j+7:8j], with the opcode in [3:0] and the argument in [7:4]. The opcodes are:
  - 0: no-op
  - 1: trigger
  - 2: store-now
  - 3: skip-store
  - 4: start-store
  - 5: stop-store
  - 6: count up
  - 7: count down
  - 8: counter reset
  - 9: timer start
  - 10: timer stop
  - 11: timer reset
  - 12: snapshot
  - 13: goto
  - 14: flag set
  - 15: flag clear

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Table/limit write strobe |
| cfg_addr_i | input | 10 | Write target {kind, state, clause} |
| cfg_wdata_i | input | 64 | Write data |
| arm_i | input | 1 | Start a new capture run |
| evt_valid_i | input | 1 | Sample valid qualifier |
| evt_i | input | 16 | Recognizer event bits of the sample |
| state_o | output | 4 | Current sequencer state |
| trig_o | output | 1 | One-shot trigger pulse |
| store_o | output | 1 | Store the qualified sample |
| snap_o | output | 1 | Snapshot pulse |
| sig_o | output | 4 | Set/clear output flags |

## Verification
The assertions check the following on every cycle:
- the one-clock width of the trigger pulse and its at-most-once-per-arm rule;
- the clearing effect of arm;
- silence of all actions and stillness of state and flags on cycles without a valid sample;
- the bounded per-clock step of both counter/timers.

Clause priority, slot decoding, gate and store arithmetic, counter latency and reset-over-step precedence depend on the programmed tables. Only the bench scenarios can show them: directed programs for each corner, and random tables compared cycle by cycle against a bench model.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int SEL_W   = 5;
  localparam int OP_W    = 4;
  localparam int ARG_W   = 4;
  localparam int SLOTS   = 8;
  localparam int ABYTE_W = OP_W + ARG_W;
  localparam int EV_W    = SLOTS * SEL_W + 1;
  localparam int ACT_W   = SLOTS * ABYTE_W;
  localparam int CNT_W   = 51;
  localparam int UNITS   = 2;
  localparam int SRC_N   = 1 << SEL_W;

  localparam logic [SEL_W-1:0] SEL_CT0 = 5'd16;
  localparam logic [SEL_W-1:0] SEL_CT1 = 5'd17;
  localparam logic [SEL_W-1:0] SEL_ANY = 5'd31;

  typedef enum logic [OP_W-1:0] {
    OP_NOP, OP_TRIG, OP_STORE, OP_NOSTORE, OP_WIN_ON, OP_WIN_OFF,
    OP_CNT_UP, OP_CNT_DN, OP_CNT_CLR, OP_TMR_GO, OP_TMR_HALT, OP_TMR_CLR,
    OP_SNAP, OP_GOTO, OP_FLAG_SET, OP_FLAG_CLR
  } op_e;

  typedef struct packed {
    logic                   trig;
    logic                   store;
    logic                   nostore;
    logic                   win_on;
    logic                   win_off;
    logic                   snap;
    logic                   go;
    logic [ARG_W-1:0]       go_st;
    logic [UNITS-1:0]       up;
    logic [UNITS-1:0]       dn;
    logic [UNITS-1:0]       clr;
    logic [UNITS-1:0]       run_go;
    logic [UNITS-1:0]       run_halt;
    logic [(1<<ARG_W)-1:0]  fset;
    logic [(1<<ARG_W)-1:0]  fclr;
  } act_ctl_t;
endpackage

// File: rtl/trig_seq_cfg.sv
module trig_seq_cfg
  import trig_seq_pkg::*;
#(
  parameter int NSTATES  = 16,
  parameter int NCLAUSES = 16,
  parameter int SB       = 4,
  parameter int CB       = 4,
  parameter int DW       = 64,
  localparam int AW      = 2 + SB + CB
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [AW-1:0]                      addr,
  input  logic [DW-1:0]                      wdata,
  input  logic [SB-1:0]                      rd_state,
  output logic [NCLAUSES-1:0][EV_W-1:0]      cl_ev,
  output logic [NCLAUSES-1:0][ACT_W-1:0]     cl_act,
  output logic [UNITS-1:0][CNT_W-1:0]        lim
);
  logic [NSTATES-1:0][NCLAUSES-1:0][EV_W-1:0]  ev_tbl;
  logic [NSTATES-1:0][NCLAUSES-1:0][ACT_W-1:0] act_tbl;
  logic [1:0]    kind;
  logic [SB-1:0] wst;
  logic [CB-1:0] wcl;

  assign kind = addr[AW-1:AW-2];
  assign wst  = addr[SB+CB-1:CB];
  assign wcl  = addr[CB-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_tbl  <= '0;
      act_tbl <= '0;
      lim     <= '0;
    end else if (we) begin
      case (kind)
        2'd0:    ev_tbl[wst][wcl]  <= wdata[EV_W-1:0];
        2'd1:    act_tbl[wst][wcl] <= wdata[ACT_W-1:0];
        2'd2:    lim[wcl[0]]       <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign cl_ev  = ev_tbl[rd_state];
  assign cl_act = act_tbl[rd_state];
endmodule

// File: rtl/trig_seq_match.sv
module trig_seq_match
  import trig_seq_pkg::*;
#(
  parameter int NCLAUSES = 16,
  parameter int NEXT     = 16,
  parameter int CB       = 4
) (
  input  logic [NCLAUSES-1:0][EV_W-1:0] cl_ev,
  input  logic [NEXT-1:0]               evt,
  input  logic [UNITS-1:0]              ct_hit,
  output logic                          hit,
  output logic [CB-1:0]                 hit_idx
);
  logic [SRC_N-1:0]    src;
  logic [NCLAUSES-1:0] cl_ok;

  always_comb begin
    src               = '0;
    src[NEXT-1:0]     = evt;
    src[SEL_CT0]      = ct_hit[0];
    src[SEL_CT1]      = ct_hit[1];
    src[SEL_ANY]      = 1'b1;
  end

  for (genvar c = 0; c < NCLAUSES; c++) begin : g_clause
    logic [SLOTS-1:0] slot_ok;
    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
      assign slot_ok[j] = src[cl_ev[c][j*SEL_W +: SEL_W]];
    end
    assign cl_ok[c] = cl_ev[c][EV_W-1] & (&slot_ok);
  end

  always_comb begin
    hit     = |cl_ok;
    hit_idx = '0;
    for (int c = NCLAUSES - 1; c >= 0; c--) begin
      if (cl_ok[c]) hit_idx = CB'(c);
    end
  end
endmodule

// File: rtl/trig_seq_act_dec.sv
module trig_seq_act_dec
  import trig_seq_pkg::*;
(
  input  logic [ACT_W-1:0] act_word,
  output act_ctl_t         ctl
);
  always_comb begin
    ctl = '0;
    for (int j = 0; j < SLOTS; j++) begin
      logic [OP_W-1:0]  op;
      logic [ARG_W-1:0] arg;
      op  = act_word[j*ABYTE_W +: OP_W];
      arg = act_word[j*ABYTE_W + OP_W +: ARG_W];
      case (op_e'(op))
        OP_TRIG:     ctl.trig          = 1'b1;
        OP_STORE:    ctl.store         = 1'b1;
        OP_NOSTORE:  ctl.nostore       = 1'b1;
        OP_WIN_ON:   ctl.win_on        = 1'b1;
        OP_WIN_OFF:  ctl.win_off       = 1'b1;
        OP_CNT_UP:   ctl.up[arg[0]]    = 1'b1;
        OP_CNT_DN:   ctl.dn[arg[0]]    = 1'b1;
        OP_CNT_CLR,
        OP_TMR_CLR:  ctl.clr[arg[0]]   = 1'b1;
        OP_TMR_GO:   ctl.run_go[arg[0]]   = 1'b1;
        OP_TMR_HALT: ctl.run_halt[arg[0]] = 1'b1;
        OP_SNAP:     ctl.snap          = 1'b1;
        OP_GOTO: begin
          ctl.go    = 1'b1;
          ctl.go_st = arg;
        end
        OP_FLAG_SET: ctl.fset[arg]     = 1'b1;
        OP_FLAG_CLR: ctl.fclr[arg]     = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trig_seq_ctr.sv
module trig_seq_ctr
  import trig_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             up,
  input  logic             dn,
  input  logic             clr,
  input  logic             run_go,
  input  logic             run_halt,
  output logic [CNT_W-1:0] val
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (!rst_n || arm) begin
      val   <= '0;
      run_q <= 1'b0;
    end else begin
      if (clr) val <= '0;
      else     val <= val + CNT_W'(run_q) + CNT_W'(up) - CNT_W'(dn);
      if (run_halt)    run_q <= 1'b0;
      else if (run_go) run_q <= 1'b1;
    end
  end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int NSTATES  = 16,
  parameter int NCLAUSES = 16,
  parameter int NEXT     = 16,
  parameter int NSIG     = 4,
  parameter int DW       = 64,
  localparam int SB      = $clog2(NSTATES),
  localparam int CB      = $clog2(NCLAUSES),
  localparam int AW      = 2 + SB + CB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we_i,
  input  logic [AW-1:0]   cfg_addr_i,
  input  logic [DW-1:0]   cfg_wdata_i,
  input  logic            arm_i,
  input  logic            evt_valid_i,
  input  logic [NEXT-1:0] evt_i,
  output logic [SB-1:0]   state_o,
  output logic            trig_o,
  output logic            store_o,
  output logic            snap_o,
  output logic [NSIG-1:0] sig_o
);
  localparam int CW = CNT_W;

  logic [NCLAUSES-1:0][EV_W-1:0]  cl_ev;
  logic [NCLAUSES-1:0][ACT_W-1:0] cl_act;
  logic [UNITS-1:0][CW-1:0]       lim;
  logic [UNITS-1:0][CW-1:0]       ctr_val;
  logic [UNITS-1:0]               ct_hit;
  logic                           hit;
  logic [CB-1:0]                  hit_idx;
  act_ctl_t                       dec_ctl;
  act_ctl_t                       ctl;
  logic                           active_q;
  logic                           trig_done_q;
  logic                           win_q;
  logic                           win_nx;
  logic                           eval_en;

  trig_seq_cfg #(
    .NSTATES(NSTATES), .NCLAUSES(NCLAUSES), .SB(SB), .CB(CB), .DW(DW)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .addr(cfg_addr_i),
    .wdata(cfg_wdata_i), .rd_state(state_o), .cl_ev(cl_ev),
    .cl_act(cl_act), .lim(lim)
  );

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    assign ct_hit[u] = (ctr_val[u] == lim[u]);
    trig_seq_ctr u_ctr (
      .clk(clk), .rst_n(rst_n), .arm(arm_i),
      .up(ctl.up[u]), .dn(ctl.dn[u]), .clr(ctl.clr[u]),
      .run_go(ctl.run_go[u]), .run_halt(ctl.run_halt[u]),
      .val(ctr_val[u])
    );
  end

  trig_seq_match #(
    .NCLAUSES(NCLAUSES), .NEXT(NEXT), .CB(CB)
  ) u_match (
    .cl_ev(cl_ev), .evt(evt_i), .ct_hit(ct_hit),
    .hit(hit), .hit_idx(hit_idx)
  );

  trig_seq_act_dec u_dec (
    .act_word(cl_act[hit_idx]),
    .ctl(dec_ctl)
  );

  assign eval_en = active_q & evt_valid_i & ~arm_i;
  assign ctl     = (eval_en && hit) ? dec_ctl : '0;
  assign win_nx  = ctl.win_off ? 1'b0 : (ctl.win_on ? 1'b1 : win_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      trig_done_q <= 1'b0;
      win_q       <= 1'b0;
      state_o     <= '0;
      trig_o      <= 1'b0;
      store_o     <= 1'b0;
      snap_o      <= 1'b0;
      sig_o       <= '0;
    end else begin
      active_q <= active_q | arm_i;
      trig_o   <= ctl.trig & ~trig_done_q;
      snap_o   <= ctl.snap;
      store_o  <= eval_en & (ctl.store | (win_nx & ~ctl.nostore));
      if (arm_i) begin
        trig_done_q <= 1'b0;
        win_q       <= 1'b0;
        state_o     <= '0;
        sig_o       <= '0;
      end else begin
        trig_done_q <= trig_done_q | ctl.trig;
        win_q       <= win_nx;
        if (ctl.go) state_o <= ctl.go_st[SB-1:0];
        sig_o <= (sig_o | ctl.fset[NSIG-1:0]) & ~ctl.fclr[NSIG-1:0];
      end
    end
  end
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int SB   = 4,
  parameter int NSIG = 4,
  parameter int CW   = 51
) (
  input logic                clk,
  input logic                rst_n,
  input logic                arm_i,
  input logic                evt_valid_i,
  input logic [SB-1:0]       state_o,
  input logic                trig_o,
  input logic                store_o,
  input logic                snap_o,
  input logic [NSIG-1:0]     sig_o,
  input logic [1:0][CW-1:0]  ctr_val
);
  logic seen_trig;

  always_ff @(posedge clk) begin
    if (!rst_n || arm_i) seen_trig <= 1'b0;
    else if (trig_o)     seen_trig <= 1'b1;
  end

  a_r6_trig_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  a_r6_trig_once: assert property (@(posedge clk) disable iff (!rst_n)
    seen_trig |-> !trig_o);

  a_r11_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (state_o == '0) && (sig_o == '0) && !trig_o && !store_o
              && !snap_o && (ctr_val[0] == '0) && (ctr_val[1] == '0));

  a_r5_no_sample_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_valid_i |=> !trig_o && !store_o && !snap_o);

  a_r5_no_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid_i && !arm_i) |=> $stable(state_o) && $stable(sig_o));

  a_r8_step0: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> (ctr_val[0] == '0) ||
               ((ctr_val[0] - $past(ctr_val[0]) + CW'(1)) <= CW'(3)));

  a_r8_step1: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> (ctr_val[1] == '0) ||
               ((ctr_val[1] - $past(ctr_val[1]) + CW'(1)) <= CW'(3)));
endmodule

bind trig_seq trig_seq_chk #(.SB(SB), .NSIG(NSIG), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .evt_valid_i(evt_valid_i),
  .state_o(state_o), .trig_o(trig_o), .store_o(store_o), .snap_o(snap_o),
  .sig_o(sig_o), .ctr_val(ctr_val)
);

// File: tb/trig_seq_tb_top.sv
module trig_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [9:0]  cfg_addr_i = '0;
  logic [63:0] cfg_wdata_i = '0;
  logic        arm_i = 1'b0;
  logic        evt_valid_i = 1'b0;
  logic [15:0] evt_i = '0;
  logic [3:0]  state_o;
  logic        trig_o, store_o, snap_o;
  logic [3:0]  sig_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trig_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .arm_i(arm_i), .evt_valid_i(evt_valid_i),
    .evt_i(evt_i), .state_o(state_o), .trig_o(trig_o), .store_o(store_o),
    .snap_o(snap_o), .sig_o(sig_o)
  );

  // bench model of the requirements
  logic [40:0] m_ev [16][16];
  logic [63:0] m_ac [16][16];
  logic [50:0] m_lim [2];
  logic [50:0] m_cnt [2];
  logic        m_run [2];
  logic [3:0]  m_st;
  logic        m_active, m_tdone, m_win;
  logic [3:0]  m_sig;
  logic        e_trig, e_store, e_snap;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] abyte(input int op, input int arg, input int slot);
    logic [63:0] w = '0;
    w[slot*8 +: 8] = {4'(arg), 4'(op)};
    return w;
  endfunction

  function automatic logic [63:0] evword(input logic en, input logic [39:0] sels);
    return {23'd0, en, sels};
  endfunction

  localparam logic [39:0] ALL_TRUE = {8{5'd31}};

  task automatic model_reset();
    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 16; c++) begin
        m_ev[s][c] = '0;
        m_ac[s][c] = '0;
      end
    for (int u = 0; u < 2; u++) begin
      m_lim[u] = '0; m_cnt[u] = '0; m_run[u] = 1'b0;
    end
    m_st = '0; m_active = 0; m_tdone = 0; m_win = 0; m_sig = '0;
    e_trig = 0; e_store = 0; e_snap = 0;
  endtask

  task automatic model_step(input logic arm, input logic valid, input logic [15:0] ev,
                            input logic we, input logic [9:0] addr, input logic [63:0] wd);
    logic [31:0] src;
    int hit;
    logic trig, store, nostore, won, woff, snap, go;
    logic [3:0] go_st, fset, fclr;
    logic [1:0] up, dn, clr, rgo, rhalt;
    logic en, ok, win_nx;
    src = '0; src[15:0] = ev;
    src[16] = (m_cnt[0] == m_lim[0]);
    src[17] = (m_cnt[1] == m_lim[1]);
    src[31] = 1'b1;
    en = m_active && valid && !arm;
    hit = -1;
    if (en)
      for (int c = 0; c < 16; c++)
        if (hit < 0 && m_ev[m_st][c][40]) begin
          ok = 1;
          for (int j = 0; j < 8; j++) if (!src[m_ev[m_st][c][5*j +: 5]]) ok = 0;
          if (ok) hit = c;
        end
    {trig, store, nostore, won, woff, snap, go} = '0;
    go_st = '0; fset = '0; fclr = '0; up = '0; dn = '0; clr = '0; rgo = '0; rhalt = '0;
    if (hit >= 0)
      for (int j = 0; j < 8; j++) begin
        logic [3:0] op, arg;
        op  = m_ac[m_st][hit][8*j +: 4];
        arg = m_ac[m_st][hit][8*j+4 +: 4];
        case (op)
          4'd1: trig = 1;       4'd2: store = 1;     4'd3: nostore = 1;
          4'd4: won = 1;        4'd5: woff = 1;      4'd6: up[arg[0]] = 1;
          4'd7: dn[arg[0]] = 1; 4'd8, 4'd11: clr[arg[0]] = 1;
          4'd9: rgo[arg[0]] = 1; 4'd10: rhalt[arg[0]] = 1;
          4'd12: snap = 1;
          4'd13: begin go = 1; go_st = arg; end
          4'd14: if (arg < 4) fset[arg[1:0]] = 1;
          4'd15: if (arg < 4) fclr[arg[1:0]] = 1;
          default: ;
        endcase
      end
    win_nx  = woff ? 1'b0 : (won ? 1'b1 : m_win);
    e_trig  = trig & ~m_tdone;
    e_snap  = snap;
    e_store = en & (store | (win_nx & ~nostore));
    for (int u = 0; u < 2; u++) begin
      if (arm) begin
        m_cnt[u] = '0; m_run[u] = 0;
      end else begin
        if (clr[u]) m_cnt[u] = '0;
        else m_cnt[u] = m_cnt[u] + 51'(m_run[u]) + 51'(up[u]) - 51'(dn[u]);
        if (rhalt[u]) m_run[u] = 0;
        else if (rgo[u]) m_run[u] = 1;
      end
    end
    if (arm) begin
      m_tdone = 0; m_win = 0; m_st = '0; m_sig = '0;
    end else begin
      m_tdone = m_tdone | trig;
      m_win = win_nx;
      if (go) m_st = go_st;
      m_sig = (m_sig | fset) & ~fclr;
    end
    m_active = m_active | arm;
    if (we) case (addr[9:8])
      2'd0: m_ev[addr[7:4]][addr[3:0]] = wd[40:0];
      2'd1: m_ac[addr[7:4]][addr[3:0]] = wd;
      2'd2: m_lim[addr[0]] = wd[50:0];
      default: ;
    endcase
  endtask

  task automatic cycle(input logic arm, input logic valid, input logic [15:0] ev,
                       input logic we = 0, input logic [9:0] addr = '0,
                       input logic [63:0] wd = '0);
    @(negedge clk);
    arm_i = arm; evt_valid_i = valid; evt_i = ev;
    cfg_we_i = we; cfg_addr_i = addr; cfg_wdata_i = wd;
    model_step(arm, valid, ev, we, addr, wd);
    @(posedge clk);
    #1;
    chk("R6 trigger vs model", 64'(trig_o), 64'(e_trig));
    chk("R7 store vs model", 64'(store_o), 64'(e_store));
    chk("R10 snapshot vs model", 64'(snap_o), 64'(e_snap));
    chk("R10 flags vs model", 64'(sig_o), 64'(m_sig));
    chk("R1 R2 R3 R4 R8 R12 state vs model", 64'(state_o), 64'(m_st));
  endtask

  task automatic wr(input int kind, input int st, input int cl, input logic [63:0] wd);
    cycle(0, 0, '0, 1, {2'(kind), 4'(st), 4'(cl)}, wd);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R11 reset state", 64'(state_o), 0);
    chk("R6 reset trigger", 64'(trig_o), 0);
    chk("R7 reset store", 64'(store_o), 0);
    chk("R10 reset flags", 64'(sig_o), 0);

    // R5: before any arm nothing evaluates
    wr(0, 0, 2, evword(1, ALL_TRUE));
    wr(1, 0, 2, abyte(13, 7, 0));
    cycle(0, 1, 16'hFFFF);
    chk("R5 unarmed no goto", 64'(state_o), 0);

    // R3 priority program in state 0
    wr(0, 0, 0, evword(0, ALL_TRUE));
    wr(1, 0, 0, abyte(13, 9, 0));
    wr(0, 0, 1, evword(1, {ALL_TRUE[39:5], 5'd3}));
    wr(1, 0, 1, abyte(13, 2, 0) | abyte(1, 0, 1) | abyte(13, 5, 2) | abyte(13, 2, 3));
    wr(0, 2, 0, evword(1, ALL_TRUE));
    wr(1, 2, 0, abyte(1, 0, 0) | abyte(6, 0, 1) | abyte(13, 3, 2));
    wr(0, 3, 0, evword(1, {ALL_TRUE[39:5], 5'd16}));
    wr(1, 3, 0, abyte(13, 4, 0));
    wr(0, 3, 1, evword(1, ALL_TRUE));
    wr(1, 3, 1, abyte(6, 0, 0));
    wr(2, 0, 0, 64'd1);
    wr(0, 4, 0, evword(1, ALL_TRUE));
    wr(1, 4, 0, abyte(4, 0, 0) | abyte(14, 1, 1) | abyte(14, 2, 2) | abyte(15, 2, 3) | abyte(12, 0, 4));

    cycle(1, 1, 16'hFFFF);
    chk("R11 arm to state 0", 64'(state_o), 0);
    chk("R11 arm blocks evaluation", 64'(trig_o), 0);
    cycle(0, 1, 16'h0000);
    chk("R3 disabled clause skipped, clause 2 goto", 64'(state_o), 7);
    cycle(0, 1, 16'hFFFF);
    chk("R4 no clause holds state", 64'(state_o), 7);
    chk("R4 no clause no trigger", 64'(trig_o), 0);

    cycle(1, 0, '0);
    cycle(0, 1, 16'h0008);
    chk("R3 lowest clause wins", 64'(state_o), 2);
    chk("R6 trigger pulse", 64'(trig_o), 1);
    cycle(0, 1, 16'h0000);
    chk("R6 trigger once per run", 64'(trig_o), 0);
    chk("R4 goto next clock", 64'(state_o), 3);
    cycle(0, 1, 16'h0000);
    chk("R9 counter visible next cycle", 64'(state_o), 4);
    cycle(0, 1, 16'h0000);
    chk("R7 start-store", 64'(store_o), 1);
    chk("R10 set/clear clear wins", 64'(sig_o), 4'b0010);
    chk("R10 snapshot pulse", 64'(snap_o), 1);
    cycle(0, 0, 16'h0000);
    chk("R5 no sample no store", 64'(store_o), 0);
    chk("R5 no sample no snapshot", 64'(snap_o), 0);
    cycle(1, 0, '0);
    chk("R11 arm clears flags", 64'(sig_o), 0);
    cycle(0, 1, 16'h0008);
    chk("R6 trigger again after re-arm", 64'(trig_o), 1);

    // random tables vs model (R1 R2 R8 R12)
    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 16; c++) begin
        logic [39:0] sels;
        logic [63:0] acts;
        for (int j = 0; j < 8; j++) begin
          int r;
          r = $urandom_range(0, 99);
          if (r < 60)      sels[5*j +: 5] = 5'd31;
          else if (r < 82) sels[5*j +: 5] = 5'($urandom_range(0, 15));
          else if (r < 97) sels[5*j +: 5] = 5'($urandom_range(16, 17));
          else             sels[5*j +: 5] = 5'($urandom_range(18, 30));
          acts[8*j +: 8] = 8'($urandom);
        end
        wr(0, s, c, evword(1'($urandom_range(0, 1)), sels));
        wr(1, s, c, acts);
      end
    wr(2, 0, 0, 64'($urandom_range(0, 6)));
    wr(2, 0, 1, 64'($urandom_range(0, 6)));
    cycle(1, 0, '0);
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] ev;
      for (int b = 0; b < 16; b++) ev[b] = ($urandom_range(0, 9) < 7);
      cycle(($urandom_range(0, 149) == 0), ($urandom_range(0, 9) < 8), ev);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule